// File: doc/BRIEF.md
# Grouped Spare-Wire Repair Fabric for an Inter-Die Link

This block sits on both ends of one vertical link between two stacked dies. It makes the link usable even when a few of its through-die wires are broken. The link has a set of regular wires, one per data bit, plus a small pool of spare wires. The regular wires are cut into equal groups, and each group owns its own slice of the spare pool. A fault map names the broken regular wires. The transmit side moves each bit whose own wire is broken onto a spare of the same group. The receive side picks the bit back up from that spare, so the original bit order is restored.

The choice of spare is fixed by rule. Inside a group, the faulty wires are counted in ascending index order, and the k-th one takes spare k of that group. Both ends compute the same mapping from the same fault map, so no negotiation between them is needed. The fault map is captured into a register only when a configure strobe is given. A registered flag tells whether every group has enough spares for its faults. The data path itself is purely combinational, so it adds no cycle of latency.

A bit can only ever reach its own wire or one of its group's spares. Each bit therefore has exactly one more candidate destination than its group has spares. This keeps the selection logic per bit small.

Top module: `tsv_repair_link`

## Requirements
- R1: While reset is high, and after it, the stored fault map is all zero and `repairable` is 1. Each regular wire then carries its own data bit, and every spare wire is 0.
- R2: The fault map and `repairable` take a new value only at a clock edge where `cfg_load` is 1. A changed `fault_in` without `cfg_load` has no effect on `wire_out`, `rx_data` or `repairable`.
- R3: A regular wire that is not marked faulty carries its own data bit, `wire_out[i] = tx_data[i]`.
- R4: A regular wire marked faulty is driven 0. Count the faulty wires of group g in ascending index order, starting at k = 0. The bit of the k-th faulty wire then appears on `wire_out[DATA_W + g*SPARES + k]`, but only if k < SPARES. Group g holds bits g*(DATA_W/GROUPS) up to (g+1)*(DATA_W/GROUPS)-1.
- R5: A spare wire that no faulty bit has been mapped to is driven 0.
- R6: With the same fault map, and `wire_in` equal to `wire_out`, every bit of a repairable link comes out on `rx_data` unchanged. This holds whatever value arrives on the faulty regular wires.
- R7: A data bit is never placed on a spare that belongs to another group. Each spare carries at most one bit.
- R8: `repairable` is 1 exactly when every group of the stored map has no more faulty wires than SPARES.
- R9: In a group with more faults than spares, the faulty bits with rank k >= SPARES come out as 0 on `rx_data`. The other bits of that group are still delivered.
- R10: `wire_out` and `rx_data` follow changes of `tx_data` and `wire_in` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fault-map register |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture `fault_in` at this clock edge |
| fault_in | input | DATA_W | Candidate fault map, 1 marks a broken regular wire |
| tx_data | input | DATA_W | Data to send over the link |
| wire_out | output | DATA_W+GROUPS*SPARES | Physical wires driven, regular in low bits, spares above |
| wire_in | input | DATA_W+GROUPS*SPARES | Physical wires received, same layout as `wire_out` |
| rx_data | output | DATA_W | Recovered data in original bit order |
| repairable | output | 1 | 1 when every group has enough spares |

## Verification
The bench uses the default build: 32 data bits in four groups of eight, with two spares per group. This size makes it cheap to reach a group with exactly as many faults as spares, a group with one fault too many, and a group where every wire is broken. It also allows faults spread over all four groups at once. Spare ranks, lost bits and group isolation can all be seen on the 40 wires. Random fault maps of sparse and dense density walk through the rank logic. Garbage is driven onto the broken regular wires at the receiver, to show that the receiver ignores them.

// File: rtl/tsv_pkg.sv
package tsv_pkg;
  // Physical position of spare k of group grp on the wire bus.
  function automatic int spare_pos(int data_w, int spares, int grp, int k);
    return data_w + grp * spares + k;
  endfunction

  // Group is coverable when its faults do not outnumber its spares.
  function automatic logic covers(int faults, int spares);
    return faults <= spares;
  endfunction
endpackage

// File: rtl/tsv_fault_store.sv
module tsv_fault_store #(
  parameter int DATA_W = 32,
  parameter int GROUPS = 4,
  parameter int SPARES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [DATA_W-1:0] fault_in,
  output logic [DATA_W-1:0] fault_q,
  output logic              repairable
);
  localparam int GW = DATA_W / GROUPS;

  logic [GROUPS-1:0] grp_fit;

  for (genvar g = 0; g < GROUPS; g++) begin : g_count
    always_comb begin : count_faults
      int c;
      c = 0;
      for (int j = 0; j < GW; j++) c = c + int'(fault_in[g*GW+j]);
      grp_fit[g] = tsv_pkg::covers(c, SPARES);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q    <= '0;
      repairable <= 1'b1;
    end else if (cfg_load) begin
      fault_q    <= fault_in;
      repairable <= &grp_fit;
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_load |=> fault_q == $past(fault_in));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> ($stable(fault_q) && $stable(repairable)));
endmodule

// File: rtl/tsv_group_route.sv
module tsv_group_route #(
  parameter int GW = 8,
  parameter int SP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] fault,
  input  logic [GW-1:0] tx_bits,
  output logic [GW-1:0] reg_drive,
  output logic [SP-1:0] spare_drive,
  input  logic [GW-1:0] reg_sense,
  input  logic [SP-1:0] spare_sense,
  output logic [GW-1:0] rx_bits,
  output logic          grp_ok
);
  localparam int CW = $clog2(GW + 1);

  logic [GW-1:0][SP-1:0] sel;   // one-hot spare choice per bit
  logic [SP-1:0][GW-1:0] col;   // which bit each spare carries
  logic [CW-1:0]         nfault;

  // Rank of each faulty wire = faults below it in the group.
  always_comb begin : rank_logic
    int c;
    c = 0;
    for (int j = 0; j < GW; j++) begin
      for (int k = 0; k < SP; k++) sel[j][k] = fault[j] && (c == k);
      c = c + int'(fault[j]);
    end
    nfault = CW'(c);
  end

  for (genvar k = 0; k < SP; k++) begin : g_col
    for (genvar j = 0; j < GW; j++) begin : g_bit
      assign col[k][j] = sel[j][k];
    end
  end

  assign grp_ok = tsv_pkg::covers(int'(nfault), SP);

  // Transmit steering
  always_comb begin
    reg_drive = tx_bits & ~fault;
    for (int k = 0; k < SP; k++) spare_drive[k] = |(col[k] & tx_bits);
  end

  // Receive unsteering
  always_comb begin
    for (int j = 0; j < GW; j++)
      rx_bits[j] = (reg_sense[j] & ~fault[j]) | (|(sel[j] & spare_sense));
  end

  for (genvar k = 0; k < SP; k++) begin : g_chk_spare
    assert_spare_one_R7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col[k]));
  end

  for (genvar j = 0; j < GW; j++) begin : g_chk_bit
    assert_lost_R9: assert property (@(posedge clk) disable iff (rst)
      (fault[j] && (sel[j] == '0)) |-> (rx_bits[j] == 1'b0));
  end

  assert_rank_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(sel) == ((int'(nfault) < SP) ? int'(nfault) : SP));
endmodule

// File: rtl/tsv_repair_link.sv
module tsv_repair_link #(
  parameter int DATA_W = 32,
  parameter int GROUPS = 4,
  parameter int SPARES = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               cfg_load,
  input  logic [DATA_W-1:0]                  fault_in,
  input  logic [DATA_W-1:0]                  tx_data,
  output logic [DATA_W+GROUPS*SPARES-1:0]    wire_out,
  input  logic [DATA_W+GROUPS*SPARES-1:0]    wire_in,
  output logic [DATA_W-1:0]                  rx_data,
  output logic                               repairable
);
  localparam int GW      = DATA_W / GROUPS;
  localparam int SPARE_W = GROUPS * SPARES;

  logic [DATA_W-1:0] fault_q;
  logic [GROUPS-1:0] grp_ok;

  tsv_fault_store #(
    .DATA_W(DATA_W), .GROUPS(GROUPS), .SPARES(SPARES)
  ) u_store (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .fault_in(fault_in),
    .fault_q(fault_q), .repairable(repairable)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    tsv_group_route #(.GW(GW), .SP(SPARES)) u_route (
      .clk        (clk),
      .rst        (rst),
      .fault      (fault_q[g*GW +: GW]),
      .tx_bits    (tx_data[g*GW +: GW]),
      .reg_drive  (wire_out[g*GW +: GW]),
      .spare_drive(wire_out[tsv_pkg::spare_pos(DATA_W, SPARES, g, 0) +: SPARES]),
      .reg_sense  (wire_in[g*GW +: GW]),
      .spare_sense(wire_in[tsv_pkg::spare_pos(DATA_W, SPARES, g, 0) +: SPARES]),
      .rx_bits    (rx_data[g*GW +: GW]),
      .grp_ok     (grp_ok[g])
    );
  end

  assert_flag_R8: assert property (@(posedge clk) disable iff (rst)
    repairable == (&grp_ok));
  assert_dead_R4: assert property (@(posedge clk) disable iff (rst)
    (wire_out[DATA_W-1:0] & fault_q) == '0);
  assert_width_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(wire_out[DATA_W +: SPARE_W]) <= $countones(tx_data & fault_q));
endmodule

// File: tb/sim_tsv_repair_link.sv
module sim_tsv_repair_link;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 32;
  localparam int G  = 4;
  localparam int S  = 2;
  localparam int GW = N / G;
  localparam int WW = N + G * S;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_load = 1'b0;
  logic [N-1:0]  fault_in = '0;
  logic [N-1:0]  tx_data = '0;
  logic [WW-1:0] wire_in = '0;
  logic [WW-1:0] wire_out;
  logic [N-1:0]  rx_data;
  logic          repairable;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;
  logic [N-1:0] cur_f = '0;

  tsv_repair_link #(.DATA_W(N), .GROUPS(G), .SPARES(S)) u0 (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .fault_in(fault_in),
    .tx_data(tx_data), .wire_out(wire_out), .wire_in(wire_in),
    .rx_data(rx_data), .repairable(repairable)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [WW-1:0] exp_wire(logic [N-1:0] f, logic [N-1:0] d);
    logic [WW-1:0] w = '0;
    for (int g = 0; g < G; g++) begin
      int c = 0;
      for (int j = 0; j < GW; j++) begin
        int i = g * GW + j;
        if (!f[i]) w[i] = d[i];
        else begin
          if (c < S) w[N + g*S + c] = d[i];
          c++;
        end
      end
    end
    return w;
  endfunction

  function automatic logic [N-1:0] exp_rx(logic [N-1:0] f, logic [WW-1:0] w);
    logic [N-1:0] r = '0;
    for (int g = 0; g < G; g++) begin
      int c = 0;
      for (int j = 0; j < GW; j++) begin
        int i = g * GW + j;
        if (!f[i]) r[i] = w[i];
        else begin
          if (c < S) r[i] = w[N + g*S + c];
          c++;
        end
      end
    end
    return r;
  endfunction

  function automatic logic exp_rep(logic [N-1:0] f);
    logic ok = 1'b1;
    for (int g = 0; g < G; g++) begin
      int c = 0;
      for (int j = 0; j < GW; j++) c += int'(f[g*GW+j]);
      if (c > S) ok = 1'b0;
    end
    return ok;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [N-1:0] f);
    @(negedge clk);
    fault_in = f;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    cur_f = f;
  endtask

  // Drive data and a loopback with garbage on faulty regular wires, then check.
  task automatic send(input logic [N-1:0] d, input string tag);
    logic [WW-1:0] ew;
    logic [WW-1:0] wi;
    ew = exp_wire(cur_f, d);
    wi = ew;
    for (int i = 0; i < N; i++) if (cur_f[i]) wi[i] = 1'($urandom);
    tx_data = d;
    wire_in = wi;
    #1;
    chk({tag, " wire_out R3/R4/R5/R7"}, 64'(wire_out), 64'(ew));
    chk({tag, " rx_data R6/R9"}, 64'(rx_data), 64'(exp_rx(cur_f, wi)));
    chk({tag, " flag R8"}, 64'(repairable), 64'(exp_rep(cur_f)));
    if (exp_rep(cur_f)) chk({tag, " lossless R6"}, 64'(rx_data), 64'(d));
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [N-1:0] f;
    logic [N-1:0] d;
    logic [WW-1:0] keep_w;
    logic [N-1:0] keep_r;
    int seed_sink;
    seed_sink = $urandom(32'd20240611);
    fault_in = 32'hFFFF_FFFF;
    tx_data = 32'hA5A5_5A5A;
    repeat (3) @(negedge clk);
    // R1: reset state visible while reset is held
    #1;
    chk("R1 flag in reset", 64'(repairable), 64'd1);
    chk("R1 wires in reset", 64'(wire_out), 64'({8'h00, 32'hA5A5_5A5A}));
    @(negedge clk);
    rst = 1'b0;
    cur_f = '0;
    send(32'h1234_5678, "R1 after reset");

    // R4: two faults in group 0 take spares 0 and 1
    load(32'h0000_0022);
    send(32'hFFFF_FFFF, "R4 g0 two");
    chk("R4 spare pos", 64'(wire_out[N +: G*S]), 64'(8'b0000_0011));
    send(32'h0000_0020, "R4 g0 bit5");
    chk("R4 rank order", 64'(wire_out[N +: G*S]), 64'(8'b0000_0010));

    // R9: three faults in group 2 (bits 16,19,22), bit 22 lost
    load(32'h0049_0000);
    send(32'hFFFF_FFFF, "R9 overflow");
    chk("R9 lost bit", 64'(rx_data[22]), 64'd0);
    chk("R9 kept bits", 64'(rx_data[19]), 64'd1);
    chk("R8 flag low", 64'(repairable), 64'd0);

    // R9: whole group 3 broken
    load(32'hFF00_0000);
    send(32'hFFFF_FFFF, "R9 full group");

    // R7: fault only in group 1, other groups' spares stay 0
    load(32'h0000_8000);
    send(32'hFFFF_FFFF, "R7 isolation");
    chk("R7 other spares", 64'(wire_out[N +: G*S] & 8'b1111_0011), 64'd0);

    // R8: exactly SPARES faults in every group
    load(32'h8181_8181);
    send(32'hDEAD_BEEF, "R8 edge full");

    // R2: fault_in change without strobe is ignored
    d = 32'hCAFE_F00D;
    send(d, "R2 base");
    keep_w = wire_out;
    keep_r = rx_data;
    fault_in = 32'h0FFF_FFF0;
    repeat (3) @(negedge clk);
    #1;
    chk("R2 wires held", 64'(wire_out), 64'(keep_w));
    chk("R2 rx held", 64'(rx_data), 64'(keep_r));
    chk("R2 flag held", 64'(repairable), 64'd1);

    // R10: combinational response between edges
    @(negedge clk);
    #2;
    tx_data = 32'h0F0F_0F0F;
    #1;
    chk("R10 no latency", 64'(wire_out), 64'(exp_wire(cur_f, 32'h0F0F_0F0F)));

    // Random fault maps, sparse and dense
    for (int it = 0; it < 400; it++) begin
      int dens;
      dens = (it % 2 == 0) ? 24 : 6;
      for (int i = 0; i < N; i++) f[i] = (($urandom % dens) == 0);
      load(f);
      for (int v = 0; v < 3; v++) send($urandom, "rand");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule